// File: doc/BRIEF.md
# Memory Tag Check Unit

This block decides, for each load or store, whether the access survives its memory tag check. An access arrives as a single-cycle strobe with its pointer address, a load/store flag, the page-tagged attribute from address translation, the stored tag of the addressed memory chunk with its valid bit, and a 4-bit configuration word for the current privilege mode. The pointer tag is the top of the address. Its width depends on the 2-bit tagging mode, and a mode of zero turns tagging off.

One cycle after the strobe, the unit presents exactly one of three outcomes. The access either passes, raises a synchronous software-check exception with trap value 4, or records an asynchronous store fault. When the configuration allows it, a pointer tag of zero skips the check. An asynchronous fault sets a sticky pending flag and captures the faulting address. Both stay until software pulses the clear input.

The access stream has no back-pressure. A strobe is accepted in every cycle, and each strobe produces one result beat one cycle later. There is no ready signal, so the consumer must take every result beat.

Top module: `mem_tag_checker`

## Requirements
- R1: When the tagging mode is 00, or the page is not marked tagged, the access passes whatever the tags are.
- R2: When the elision bit is set and the active-width pointer tag is zero, the access passes. This holds even when the stored tag is marked invalid.
- R3: When the elision bit is clear, an access to a tagged page with mode not 00 is checked even if its pointer tag is zero.
- R4: A checked access whose stored tag valid bit is 0 fails the check.
- R5: A checked access fails when the pointer tag and the stored tag differ within the active width, which is 4 bits for mode 01, 6 bits for mode 10 and 8 bits for mode 11. The pointer tag is taken from the topmost address bits, and stored-tag bits above the active width are ignored.
- R6: A failed check reports a synchronous fault with trap value 4, except for a store with the asynchronous bit set, which reports an asynchronous fault. Loads always fail synchronously.
- R7: An asynchronous fault sets `async_pending` and latches the access address in the same edge as the result. Later asynchronous faults leave the address unchanged while the flag is set. `async_clr` clears the flag, but an asynchronous fault in the clear cycle sets it again with the new address.
- R8: `res_valid` rises exactly one cycle after `acc_valid`. While it is high, exactly one of pass, sync fault and async fault is high, and `res_tval` is 4 only on a sync fault and 0 otherwise. While it is low, all outcome outputs are 0.
- R9: The configuration word is laid out as follows: bits [1:0] hold the tagging mode, bit 2 enables asynchronous store reporting, and bit 3 enables zero-tag elision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one beat per access |
| acc_addr | input | ADDR_W | Pointer address including tag bits |
| acc_is_store | input | 1 | 1 for store, 0 for load |
| acc_page_tagged | input | 1 | Page marked tagged by translation |
| acc_mem_tag | input | TAG_W3 | Stored tag of the addressed chunk |
| acc_mem_tag_ok | input | 1 | Stored tag valid bit |
| acc_cfg | input | 4 | Mode configuration word |
| async_clr | input | 1 | Clears the pending asynchronous fault |
| res_valid | output | 1 | Result beat |
| res_pass | output | 1 | Access passed |
| res_sync_fault | output | 1 | Synchronous software-check exception |
| res_async_fault | output | 1 | Asynchronous store fault recorded |
| res_tval | output | 4 | Trap value |
| async_pending | output | 1 | Sticky asynchronous fault flag |
| async_addr | output | ADDR_W | Address of first pending asynchronous fault |

## Verification
A wrong width selection or a wrong mask shows up on the first access whose tags differ only in the bits around the active width: the next result beat is a fault where a pass was expected, or the other way round. A wrong elision or gating decision shows up one cycle after a zero-tag or untagged-page access. If the pending flag is wrong, or the held address is overwritten, the effect stays visible at `async_pending` and `async_addr` until the next clear. The bench therefore checks these outputs after every access, not only after asynchronous ones.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

  typedef enum logic [1:0] {
    OUT_PASS  = 2'd0,
    OUT_SYNC  = 2'd1,
    OUT_ASYNC = 2'd2
  } outcome_e;

  typedef struct packed {
    logic       elide_en;
    logic       async_en;
    logic [1:0] mode;
  } mode_cfg_t;

  localparam logic [3:0] TRAP_TAG_CHECK = 4'd4;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/mtc_tag_extract.sv
module mtc_tag_extract #(
  parameter int TAG_W1 = 4,
  parameter int TAG_W2 = 6,
  parameter int TAG_W3 = 8,
  localparam int TMAX = mtc_pkg::max3(TAG_W1, TAG_W2, TAG_W3)
) (
  input  logic [TMAX-1:0] addr_hi,
  input  logic [1:0]      mode,
  output logic [TMAX-1:0] ptr_tag,
  output logic [TMAX-1:0] tag_mask
);

  logic [TMAX-1:0] cand_tag  [4];
  logic [TMAX-1:0] cand_mask [4];

  assign cand_tag[0]  = '0;
  assign cand_mask[0] = '0;

  for (genvar g = 1; g < 4; g++) begin : g_width
    localparam int W = (g == 1) ? TAG_W1 : ((g == 2) ? TAG_W2 : TAG_W3);
    logic [TMAX-1:0] t_q, m_q;
    always_comb begin
      t_q = '0;
      m_q = '0;
      t_q[W-1:0] = addr_hi[TMAX-1 -: W];
      m_q[W-1:0] = '1;
    end
    assign cand_tag[g]  = t_q;
    assign cand_mask[g] = m_q;
  end

  assign ptr_tag  = cand_tag[mode];
  assign tag_mask = cand_mask[mode];

endmodule

// File: rtl/mtc_decide.sv
module mtc_decide #(
  parameter int TMAX = 8
) (
  input  logic [TMAX-1:0]     ptr_tag,
  input  logic [TMAX-1:0]     tag_mask,
  input  logic [TMAX-1:0]     mem_tag,
  input  logic                mem_tag_ok,
  input  logic                page_tagged,
  input  logic                is_store,
  input  mtc_pkg::mode_cfg_t  cfg,
  output mtc_pkg::outcome_e   outcome
);
  import mtc_pkg::*;

  logic checking, elided, failed;

  always_comb begin
    checking = (cfg.mode != 2'b00) && page_tagged;
    // elision is judged before the stored tag valid bit is looked at
    elided   = cfg.elide_en && ((ptr_tag & tag_mask) == '0);
    failed   = !mem_tag_ok || (((ptr_tag ^ mem_tag) & tag_mask) != '0);
    if (!checking || elided || !failed) outcome = OUT_PASS;
    else if (is_store && cfg.async_en)   outcome = OUT_ASYNC;
    else                                 outcome = OUT_SYNC;
  end

  always_comb begin
    if (outcome == OUT_ASYNC) begin
      AST_ASYNC_ONLY_STORE: assert (is_store); // R6
    end
    if (outcome != OUT_PASS) begin
      AST_FAULT_NEEDS_CHECK: assert (checking && !elided); // R1
    end
  end

endmodule

// File: rtl/mtc_async_rec.sv
module mtc_async_rec #(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_in,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic              clr,
  output logic              pending,
  output logic [ADDR_W-1:0] held_addr
);

  logic take;
  assign take = fault_in && (!pending || clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      held_addr <= '0;
    end else begin
      pending <= fault_in || (pending && !clr);
      if (take) held_addr <= fault_addr;
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pending) && !$past(clr) |-> $stable(held_addr)); // R7

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pending) && !$past(clr) |-> pending); // R7

endmodule

// File: rtl/mem_tag_checker.sv
module mem_tag_checker #(
  parameter int ADDR_W = 48,
  parameter int TAG_W1 = 4,
  parameter int TAG_W2 = 6,
  parameter int TAG_W3 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_is_store,
  input  logic              acc_page_tagged,
  input  logic [TAG_W3-1:0] acc_mem_tag,
  input  logic              acc_mem_tag_ok,
  input  logic [3:0]        acc_cfg,
  input  logic              async_clr,
  output logic              res_valid,
  output logic              res_pass,
  output logic              res_sync_fault,
  output logic              res_async_fault,
  output logic [3:0]        res_tval,
  output logic              async_pending,
  output logic [ADDR_W-1:0] async_addr
);
  import mtc_pkg::*;

  localparam int TMAX = max3(TAG_W1, TAG_W2, TAG_W3);

  mode_cfg_t       cfg;
  logic [TMAX-1:0] ptr_tag, tag_mask, mem_tag;
  outcome_e        dec, out_q;
  logic            valid_q;

  assign cfg     = mode_cfg_t'(acc_cfg);
  assign mem_tag = TMAX'(acc_mem_tag);

  mtc_tag_extract #(.TAG_W1(TAG_W1), .TAG_W2(TAG_W2), .TAG_W3(TAG_W3)) u_extract (
    .addr_hi  (acc_addr[ADDR_W-1 -: TMAX]),
    .mode     (cfg.mode),
    .ptr_tag  (ptr_tag),
    .tag_mask (tag_mask)
  );

  mtc_decide #(.TMAX(TMAX)) u_decide (
    .ptr_tag     (ptr_tag),
    .tag_mask    (tag_mask),
    .mem_tag     (mem_tag),
    .mem_tag_ok  (acc_mem_tag_ok),
    .page_tagged (acc_page_tagged),
    .is_store    (acc_is_store),
    .cfg         (cfg),
    .outcome     (dec)
  );

  mtc_async_rec #(.ADDR_W(ADDR_W)) u_async (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_in   (acc_valid && (dec == OUT_ASYNC)),
    .fault_addr (acc_addr),
    .clr        (async_clr),
    .pending    (async_pending),
    .held_addr  (async_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      out_q   <= OUT_PASS;
    end else begin
      valid_q <= acc_valid;
      if (acc_valid) out_q <= dec;
    end
  end

  assign res_valid       = valid_q;
  assign res_pass        = valid_q && (out_q == OUT_PASS);
  assign res_sync_fault  = valid_q && (out_q == OUT_SYNC);
  assign res_async_fault = valid_q && (out_q == OUT_ASYNC);
  assign res_tval        = res_sync_fault ? TRAP_TAG_CHECK : 4'd0;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $countones({res_pass, res_sync_fault, res_async_fault}) == 1); // R8

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !(res_pass || res_sync_fault || res_async_fault) && res_tval == 4'd0); // R8

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid) |-> res_valid); // R8

  AST_ASYNC_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    res_async_fault |-> async_pending); // R7

  AST_SYNC_TVAL: assert property (@(posedge clk) disable iff (!rst_n)
    res_sync_fault |-> res_tval == 4'd4); // R6

endmodule

// File: tb/mem_tag_checker_test.sv
module mem_tag_checker_test;
  localparam int AW = 48;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          acc_valid = 0;
  logic [AW-1:0] acc_addr = '0;
  logic          acc_is_store = 0;
  logic          acc_page_tagged = 0;
  logic [7:0]    acc_mem_tag = '0;
  logic          acc_mem_tag_ok = 0;
  logic [3:0]    acc_cfg = '0;
  logic          async_clr = 0;
  logic          res_valid, res_pass, res_sync_fault, res_async_fault;
  logic [3:0]    res_tval;
  logic          async_pending;
  logic [AW-1:0] async_addr;

  int total = 0;
  int bad = 0;
  bit            m_pend = 0;
  logic [AW-1:0] m_addr = '0;

  mem_tag_checker uut (.*);

  always #5 clk = ~clk;

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wid(logic [1:0] m);
    case (m)
      2'b01:   return 4;
      2'b10:   return 6;
      2'b11:   return 8;
      default: return 0;
    endcase
  endfunction

  // 0 pass, 1 sync, 2 async
  function automatic int model(logic [AW-1:0] a, bit st, bit pg, logic [7:0] mt,
                               bit ok, logic [3:0] c);
    int w = wid(c[1:0]);
    logic [7:0] mask, pt;
    if (w == 0 || !pg) return 0;
    mask = 8'((1 << w) - 1);
    pt   = 8'(a >> (AW - w));
    if (c[3] && pt == 0) return 0;
    if (ok && ((pt ^ mt) & mask) == 0) return 0;
    return (st && c[2]) ? 2 : 1;
  endfunction

  task automatic access(string req, logic [AW-1:0] a, bit st, bit pg,
                        logic [7:0] mt, bit ok, logic [3:0] c, bit clr);
    int e;
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_is_store = st; acc_page_tagged = pg;
    acc_mem_tag = mt; acc_mem_tag_ok = ok; acc_cfg = c; async_clr = clr;
    e = model(a, st, pg, mt, ok, c);
    if (e == 2 && (!m_pend || clr)) m_addr = a;
    m_pend = (e == 2) || (m_pend && !clr);
    @(negedge clk);
    acc_valid = 0; async_clr = 0;
    chk({req, " valid"}, res_valid, 1);
    chk({req, " outcome"}, {res_async_fault, res_sync_fault, res_pass},
        (e == 0) ? 1 : (e == 1) ? 2 : 4);
    chk({req, " tval"}, res_tval, (e == 1) ? 4 : 0);
    chk({req, " pending"}, async_pending, m_pend);
    chk({req, " addr"}, async_addr, m_addr);
  endtask

  function automatic logic [AW-1:0] mk(logic [7:0] top, int w);
    return ({top, 40'h0} & ~({AW{1'b1}} >> w)) | AW'(48'h0000_1234_5678);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset valid", res_valid, 0);
    chk("R7 reset pending", async_pending, 0);
    chk("R7 reset addr", async_addr, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R8 idle outcome", {res_pass, res_sync_fault, res_async_fault}, 0);

    access("R1 mode00", mk(8'hA0, 4), 0, 1, 8'h00, 0, 4'b0000, 0);
    access("R1 untagged page", mk(8'hA0, 4), 0, 0, 8'h00, 0, 4'b0001, 0);
    access("R2 elide invalid", mk(8'h00, 8), 0, 1, 8'h55, 0, 4'b1011, 0);
    access("R3 zero checked", mk(8'h00, 8), 0, 1, 8'h55, 1, 4'b0011, 0);
    access("R4 invalid stored", mk(8'h30, 4), 0, 1, 8'h03, 0, 4'b0001, 0);
    access("R5 match w4 upper ignored", mk(8'h30, 4), 0, 1, 8'hF3, 1, 4'b0001, 0);
    access("R5 match w6", mk(8'hB4, 6), 0, 1, 8'hED, 1, 4'b1010, 0);
    access("R5 mismatch w8", mk(8'hB4, 8), 0, 1, 8'hB5, 1, 4'b0011, 0);
    access("R9 async bit load sync", mk(8'h10, 4), 0, 1, 8'h02, 1, 4'b0101, 0);
    access("R6 store async", mk(8'h10, 4), 1, 1, 8'h02, 1, 4'b0101, 0);
    access("R7 second async keeps addr", mk(8'h20, 4) ^ 48'h1, 1, 1, 8'h05, 1, 4'b0101, 0);
    @(negedge clk); async_clr = 1;
    @(negedge clk); async_clr = 0;
    chk("R7 clear", async_pending, 0);
    m_pend = 0;
    access("R7 fault in clear cycle", mk(8'h40, 4) ^ 48'h7, 1, 1, 8'h00, 1, 4'b0101, 1);
    access("R6 store sync when async off", mk(8'h40, 4), 1, 1, 8'h00, 1, 4'b0001, 0);

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic [7:0] mt;
      logic [3:0] c;
      int w;
      c = 4'($urandom(32'd0) & 0) | 4'($urandom);
      a = {$urandom, $urandom} & {AW{1'b1}};
      if ($urandom % 4 == 0) a[AW-1 -: 8] = 8'h00;
      w = wid(c[1:0]);
      mt = 8'($urandom);
      if (w != 0 && $urandom % 2 == 0)
        mt = 8'(a >> (AW - w)) | (8'($urandom) & ~8'((1 << w) - 1));
      access("R5 random", a, 1'($urandom), ($urandom % 5) != 0, mt,
             ($urandom % 6) != 0, c, ($urandom % 8) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule